// File: doc/BRIEF.md
# Synchronous-to-Asynchronous Receive Converter

This block sits on the receive side of a line adapter. A synchronous bit stream arrives one bit per rising edge of an external receive clock, and the block rebuilds start-stop characters from it on an asynchronous output. The synchronous channel may run a little faster than the nominal character rate. To allow this, the far end may drop a stop bit. The block finds the start of each character and counts the configured number of bits. Every bit is replayed on a timebase of 16 oversampling ticks per bit. When a stop position carries space instead of mark, the block puts back a shortened stop bit, and the slower asynchronous output stays in step with the faster synchronous input.

The whole design runs in one clock domain. The receive clock reaches the block as `rx_edge`, a one-cycle strobe marking each rising edge. The oversampling timebase reaches it as `os_tick`, a one-cycle strobe at 16 times the bit rate. Two mode inputs bypass the converter entirely. One selects fully synchronous operation. The other selects the direct mode used with faster synchronous timing. In both, the input appears unchanged on the output.

Top module: `rx_sync2async`

## Requirements
- R1: After reset, and whenever no character is being replayed, `rx_data_out` is 1 (mark). A mark-only input stream does not disturb it.
- R2: While `sync_bypass` is 1, `rx_data_out` equals `rx_data_in` in the same cycle, whatever the other inputs are.
- R3: While `buffered_mode` is 0 and `sync_bypass` is 0, `rx_data_out` equals `rx_data_in` in the same cycle.
- R4: `char_len` sets the total character length including start and stop: code 0 gives 8 bits, 1 gives 9, 2 gives 10 and 3 gives 11. The bits between start and stop (data and optional parity) number the length minus 2.
- R5: In conversion mode, the start bit, data bits and stop bit come out in the order they were received. Each lasts exactly 16 `os_tick` periods. The output changes only in a cycle that follows an `os_tick`.
- R6: With `ext_rate` at 0, a stop position that carries space, in a character that is not all space, is replayed as a 12-tick mark followed by the start bit of the next character.
- R7: With `ext_rate` at 1, the inserted stop bit of R6 lasts 10 ticks.
- R8: When a whole character is space, stop position included, the block treats it as a break. It outputs continuous space, 16 ticks per received bit, until a mark is received. That mark is replayed for 16 ticks and then the output idles.
- R9: A character whose data bits are all space but whose stop bit is mark is an ordinary character, not a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_edge | input | 1 | One-cycle strobe at each rising edge of the synchronous receive clock |
| os_tick | input | 1 | One-cycle strobe at 16 times the nominal bit rate |
| rx_data_in | input | 1 | Synchronous receive data, 1 = mark |
| char_len | input | 2 | Character length code (8 to 11 bits) |
| ext_rate | input | 1 | 1 = extended overspeed tolerance (10-tick inserted stop) |
| sync_bypass | input | 1 | 1 = synchronous operation, input copied to output |
| buffered_mode | input | 1 | 1 = normal conversion, 0 = direct connection |
| rx_data_out | output | 1 | Asynchronous receive data, 1 = mark |

## Verification
The bench replays characters of every length, with and without a deleted stop, and compares the output tick by tick from the first falling edge. A design that got the stop position wrong would shift or corrupt every later bit. A wrong inserted-stop length shows up as a second character displaced by 2 to 6 ticks in basic or extended mode. A character whose data bits are all space but whose stop is mark must come out as a normal character. A converter that flags a break too early would hold space past the stop. A true break must stay low for the whole received run. Both bypass modes are checked for the same-cycle copy, where a converter left in the path would delay or idle the output.

// File: rtl/rx_sync2async.sv
module rx_sync2async #(
  parameter int FIFO_AW          = 3,
  parameter int TICKS_PER_BIT    = 16,
  parameter int STOP_TICKS_BASIC = 12,
  parameter int STOP_TICKS_EXT   = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_edge,
  input  logic       os_tick,
  input  logic       rx_data_in,
  input  logic [1:0] char_len,
  input  logic       ext_rate,
  input  logic       sync_bypass,
  input  logic       buffered_mode,
  output logic       rx_data_out
);
  localparam int DEPTH = 1 << FIFO_AW;
  localparam int CW    = $clog2(TICKS_PER_BIT);
  localparam logic [CW-1:0] LAST_TICK = CW'(TICKS_PER_BIT - 1);

  typedef enum logic [1:0] {F_HUNT, F_CHAR, F_BRK} fstate_t;
  typedef enum logic [1:0] {O_IDLE, O_INS, O_BIT} ostate_t;

  logic run;
  assign run = buffered_mode & ~sync_bypass;

  fstate_t    fst;
  logic [3:0] pos;
  logic       allz;
  logic [3:0] stop_pos;
  assign stop_pos = 4'd7 + {2'b00, char_len};

  logic push_en, push_ins;
  logic [FIFO_AW:0] wptr, rptr;
  logic [1:0] mem [DEPTH];
  logic full, empty;
  assign empty = (wptr == rptr);
  assign full  = ((wptr ^ rptr) == {1'b1, {FIFO_AW{1'b0}}});

  always_comb begin
    push_en  = 1'b0;
    push_ins = 1'b0;
    if (run && rx_edge) begin
      case (fst)
        F_HUNT: push_en = ~rx_data_in;
        F_CHAR: begin
          push_en  = 1'b1;
          push_ins = (pos == stop_pos) && !rx_data_in && !allz;
        end
        default: push_en = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst  <= F_HUNT;
      pos  <= '0;
      allz <= 1'b0;
    end else if (!run) begin
      fst  <= F_HUNT;
      pos  <= '0;
      allz <= 1'b0;
    end else if (rx_edge) begin
      case (fst)
        F_HUNT: if (!rx_data_in) begin
          fst  <= F_CHAR;
          pos  <= 4'd1;
          allz <= 1'b1;
        end
        F_CHAR: begin
          if (pos != stop_pos) begin
            pos  <= pos + 4'd1;
            allz <= allz & ~rx_data_in;
          end else if (rx_data_in) begin
            fst <= F_HUNT;
          end else if (allz) begin
            fst <= F_BRK;
          end else begin
            pos  <= 4'd1;
            allz <= 1'b1;
          end
        end
        default: if (rx_data_in) fst <= F_HUNT;
      endcase
    end
  end

  ostate_t       ost;
  logic [CW-1:0] cnt;
  logic          out_q, pend;
  logic [1:0]    head;
  logic [CW-1:0] ins_last;
  logic          pop;

  assign head     = mem[rptr[FIFO_AW-1:0]];
  assign ins_last = ext_rate ? CW'(STOP_TICKS_EXT - 1) : CW'(STOP_TICKS_BASIC - 1);
  assign pop      = run && os_tick && !empty &&
                    (ost == O_IDLE || (ost == O_BIT && cnt == LAST_TICK));

  always_ff @(posedge clk) begin
    if (push_en && !full) mem[wptr[FIFO_AW-1:0]] <= {push_ins, rx_data_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (!run) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push_en && !full) wptr <= wptr + 1'b1;
      if (pop) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ost   <= O_IDLE;
      cnt   <= '0;
      out_q <= 1'b1;
      pend  <= 1'b1;
    end else if (!run) begin
      ost   <= O_IDLE;
      cnt   <= '0;
      out_q <= 1'b1;
      pend  <= 1'b1;
    end else if (os_tick) begin
      if (ost == O_INS) begin
        if (cnt == ins_last) begin
          ost   <= O_BIT;
          out_q <= pend;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (ost == O_BIT && cnt != LAST_TICK) begin
        cnt <= cnt + 1'b1;
      end else if (!empty) begin
        cnt <= '0;
        if (head[1]) begin
          ost   <= O_INS;
          out_q <= 1'b1;
          pend  <= head[0];
        end else begin
          ost   <= O_BIT;
          out_q <= head[0];
        end
      end else begin
        ost   <= O_IDLE;
        out_q <= 1'b1;
      end
    end
  end

  assign rx_data_out = run ? out_q : rx_data_in;
endmodule

// File: rtl/rx_sync2async_chk.sv
module rx_sync2async_chk #(
  parameter int TICKS_PER_BIT    = 16,
  parameter int STOP_TICKS_BASIC = 12,
  parameter int STOP_TICKS_EXT   = 10
) (
  input logic clk,
  input logic rst_n,
  input logic os_tick,
  input logic ext_rate,
  input logic sync_bypass,
  input logic buffered_mode,
  input logic rx_data_out
);
  logic conv, conv_d, prev_out, valid;
  logic [7:0] run_cnt, min_mark;
  assign conv     = buffered_mode & ~sync_bypass;
  assign min_mark = ext_rate ? 8'(STOP_TICKS_EXT) : 8'(STOP_TICKS_BASIC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_out <= 1'b1;
      conv_d   <= 1'b0;
      valid    <= 1'b0;
      run_cnt  <= '0;
    end else begin
      prev_out <= rx_data_out;
      conv_d   <= conv;
      if (!conv || !conv_d) begin
        valid <= 1'b0;
      end else if (rx_data_out != prev_out) begin
        valid   <= 1'b1;
        run_cnt <= os_tick ? 8'd1 : 8'd0;
      end else if (os_tick && run_cnt != 8'hFF) begin
        run_cnt <= run_cnt + 8'd1;
      end
    end
  end

  assert_reset_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (conv && $rose(rst_n)) |-> rx_data_out);

  assert_tick_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv && $past(conv) && !$past(os_tick)) |-> $stable(rx_data_out));

  assert_space_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv && valid && !prev_out && rx_data_out) |-> (run_cnt >= 8'(TICKS_PER_BIT)));

  // covers R6 and R7: no mark shorter than the inserted stop for the selected tolerance
  assert_mark_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv && valid && prev_out && !rx_data_out) |-> (run_cnt >= min_mark));
endmodule

bind rx_sync2async rx_sync2async_chk #(
  .TICKS_PER_BIT(TICKS_PER_BIT),
  .STOP_TICKS_BASIC(STOP_TICKS_BASIC),
  .STOP_TICKS_EXT(STOP_TICKS_EXT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .ext_rate(ext_rate),
  .sync_bypass(sync_bypass), .buffered_mode(buffered_mode), .rx_data_out(rx_data_out)
);

// File: tb/rx_sync2async_test.sv
module rx_sync2async_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int EDGE_DIV   = 56;
  localparam int CAP_N      = 700;
  localparam int NVEC       = 9;
  // {char_len, ext_rate, deleted_stop, data1[8:0], data2[8:0]}
  localparam logic [21:0] VECS [NVEC] = '{
    {2'd0, 1'b0, 1'b0, 9'h02D, 9'h000},
    {2'd1, 1'b0, 1'b0, 9'h055, 9'h000},
    {2'd2, 1'b0, 1'b0, 9'h0A3, 9'h000},
    {2'd3, 1'b0, 1'b0, 9'h1C6, 9'h000},
    {2'd2, 1'b0, 1'b1, 9'h03C, 9'h0F0},
    {2'd2, 1'b1, 1'b1, 9'h081, 9'h05A},
    {2'd0, 1'b1, 1'b1, 9'h021, 9'h01E},
    {2'd3, 1'b0, 1'b1, 9'h101, 9'h0FF},
    {2'd2, 1'b0, 1'b0, 9'h000, 9'h000}
  };

  logic clk = 0, rst_n = 0, rx_edge = 0, os_tick = 0, rx_data_in = 1;
  logic [1:0] char_len = 0;
  logic ext_rate = 0, sync_bypass = 0, buffered_mode = 1;
  logic rx_data_out;
  int total = 0, bad = 0, cyc = 0, eidx = 0;
  logic cap [CAP_N];
  logic expv [CAP_N];

  rx_sync2async uut (
    .clk(clk), .rst_n(rst_n), .rx_edge(rx_edge), .os_tick(os_tick),
    .rx_data_in(rx_data_in), .char_len(char_len), .ext_rate(ext_rate),
    .sync_bypass(sync_bypass), .buffered_mode(buffered_mode), .rx_data_out(rx_data_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    os_tick <= (cyc % TICK_DIV) == 0;
    rx_edge <= (cyc % EDGE_DIV) == 0;
  end

  task automatic check(input string req, input logic act, input logic expd);
    total++;
    if (act !== expd) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, expd);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    rx_data_in = b;
    while (!rx_edge) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_char(input int n, input logic [8:0] d, input logic stop);
    send_bit(1'b0);
    for (int b = 0; b < n - 2; b++) send_bit(d[b]);
    if (stop) send_bit(1'b1);
  endtask

  task automatic add_seg(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      if (eidx < CAP_N) expv[eidx] = v;
      eidx++;
    end
  endtask

  task automatic capture();
    for (int i = 0; i < CAP_N; i++) begin
      do @(negedge clk); while (!os_tick);
      cap[i] = rx_data_out;
    end
  endtask

  task automatic compare(input string req);
    int f, miss, first;
    f = -1; miss = 0; first = -1;
    for (int i = CAP_N - 1; i >= 0; i--) if (cap[i] === 1'b0) f = i;
    total++;
    if (f < 0) begin
      bad++;
      $display("FAIL %s actual=no start seen expected=start bit", req);
      return;
    end
    for (int i = 0; i < CAP_N - f; i++)
      if (cap[f + i] !== expv[i]) begin
        miss++;
        if (first < 0) first = i;
      end
    if (miss != 0) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at tick %0d (%0d ticks differ)",
               req, cap[f + first], expv[first], first, miss);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 in reset", rx_data_out, 1'b1);
    do_reset();
    check("R1 after reset", rx_data_out, 1'b1);

    // R1: mark-only input leaves the output idle
    begin
      logic seen;
      seen = 1'b1;
      for (int i = 0; i < 40 * EDGE_DIV; i++) begin
        @(negedge clk);
        seen &= rx_data_out;
      end
      check("R1 idle mark stream", seen, 1'b1);
    end

    // R4 R5 R6 R7 R9: vector table
    for (int v = 0; v < NVEC; v++) begin
      int n;
      logic ext, del;
      logic [8:0] d1, d2;
      string tag;
      char_len = VECS[v][21:20];
      ext = VECS[v][19];
      del = VECS[v][18];
      d1 = VECS[v][17:9];
      d2 = VECS[v][8:0];
      ext_rate = ext;
      n = 8 + int'(char_len);
      tag = del ? (ext ? "R7 inserted stop" : "R6 inserted stop")
                : (d1 == 0 ? "R9 null char" : "R4/R5 char replay");
      for (int i = 0; i < CAP_N; i++) expv[i] = 1'b1;
      eidx = 0;
      add_seg(1'b0, 16);
      for (int b = 0; b < n - 2; b++) add_seg(d1[b], 16);
      if (del) begin
        add_seg(1'b1, ext ? 10 : 12);
        add_seg(1'b0, 16);
        for (int b = 0; b < n - 2; b++) add_seg(d2[b], 16);
      end
      add_seg(1'b1, 16);
      rx_data_in = 1;
      do_reset();
      fork
        capture();
        begin
          send_char(n, d1, !del);
          if (del) send_char(n, d2, 1'b1);
          rx_data_in = 1;
        end
      join
      compare(tag);
    end

    // R8: break of 25 space bits with a 10-bit character
    char_len = 2'd2;
    ext_rate = 0;
    for (int i = 0; i < CAP_N; i++) expv[i] = 1'b1;
    eidx = 0;
    add_seg(1'b0, 25 * 16);
    rx_data_in = 1;
    do_reset();
    fork
      capture();
      begin
        for (int i = 0; i < 25; i++) send_bit(1'b0);
        send_bit(1'b1);
      end
    join
    compare("R8 break");

    // R2: synchronous bypass copies input in the same cycle
    sync_bypass = 1;
    buffered_mode = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rx_data_in = i[0];
      #1;
      check("R2 bypass copy", rx_data_out, rx_data_in);
    end
    buffered_mode = 0;
    rx_data_in = 0;
    #1;
    check("R2 bypass with direct mode", rx_data_out, 1'b0);

    // R3: direct mode
    sync_bypass = 0;
    buffered_mode = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rx_data_in = ~i[0];
      #1;
      check("R3 direct copy", rx_data_out, rx_data_in);
    end

    buffered_mode = 1;
    rx_data_in = 1;
    @(negedge clk);
    check("R1 back to conversion idle", rx_data_out, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule